// File: doc/BRIEF.md
# One-Hot Modular Residue Reducer

This block takes an unsigned word and reports its remainder modulo a small odd constant chosen at elaboration. The remainder comes out as a one-hot vector with one line per possible value. It contains no divider and no binary adder. The word is cut into 2-bit slices, and each slice is decoded straight to a one-hot residue. A binary tree of one-hot merges then combines the slices back up to the full width.

At each merge the upper operand stands for `high * 2^N`. Its residue is multiplied by the constant `2^N mod M`. Because that factor is coprime to an odd modulus, the multiplication is only a fixed reordering of wires, worked out per tree level while the design is elaborated. The scaled residue and the lower residue then go through a one-hot adder table. Line k of the table's output is the OR of every AND pair whose indices sum to k modulo M.

A parameter selects between a purely combinational result and a single registered stage. In the registered variant the output is marked by a valid flag one clock after the input's valid flag, and a synchronous reset clears both.

Top module: `residue_reduce`

## Requirements
- R1: For every input value, line k of `res_onehot` is high exactly when `in_data mod MOD == k`, and no other line is high. In registered mode this applies whenever `out_valid` is high.
- R2: The 2-bit leaf slices decode their values 0 to 3 to the residues value mod MOD. With MOD=3 the value 3 therefore lights line 0. An input below 4 gives line `in_data` for any MOD of 5 or more.
- R3: Bits above the lowest slice are weighted by `2^position mod MOD`. For example, MOD=5 with `in_data`=4 lights line 4, and `in_data`=8 lights line 3.
- R4: With `REG_OUT`=0 the residue and `out_valid` follow `in_data` and `in_valid` in the same cycle, with no clock involved.
- R5: With `REG_OUT`=1, an input presented with `in_valid` high at a rising edge appears on `res_onehot` after that edge, with `out_valid` high for exactly that one cycle. Results keep input order.
- R6: With `REG_OUT`=1, a cycle with `in_valid` low gives `out_valid` low after the next edge. It leaves `res_onehot` unchanged whatever `in_data` carries.
- R7: With `REG_OUT`=1, `rst` high at a rising edge drives `out_valid` and every line of `res_onehot` to 0, even if `in_valid` is high in that cycle.
- R8: The all-zero input lights line 0. The all-ones input lights line `(2^WIDTH - 1) mod MOD`, which is line 3 for WIDTH=32 and MOD=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Marks `in_data` as a value to reduce |
| in_data | input | WIDTH | Unsigned word to reduce |
| out_valid | output | 1 | Marks `res_onehot` as a fresh result |
| res_onehot | output | MOD | One-hot remainder, line k means residue k |

## Verification
The hardest condition to reach from the ports is a merge level whose scaling factor is neither 1 nor its own inverse. With modulus 7 the factors 2 and 4 alternate up the tree, so a wrong permutation at one level shows up only for inputs with bits set in that level's upper halves. A 32-bit, modulus-7 instance is therefore driven with ten thousand random words plus both extreme words, with idle cycles mixed in. Narrower modulus-5 and modulus-3 instances are swept over every input value, which covers every leaf code and every scaled line at each level.

// File: rtl/residue_pkg.sv
`timescale 1ns/1ps
package residue_pkg;

  // residue of 2^n modulo m, evaluated at elaboration
  function automatic int pow2_mod(input int n, input int m);
    int r;
    r = 1 % m;
    for (int i = 0; i < n; i++) r = (r * 2) % m;
    return r;
  endfunction

  function automatic int floor_log2(input int x);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++)
      if ((x >> (i + 1)) != 0) r = i + 1;
    return r;
  endfunction

  function automatic bit is_pow2(input int x);
    return (x > 0) && ((x & (x - 1)) == 0);
  endfunction

endpackage

// File: rtl/res_leaf.sv
`timescale 1ns/1ps
module res_leaf #(
  parameter int MOD = 5
) (
  input  logic [1:0]     slice,
  output logic [MOD-1:0] onehot
);
  // each 2-bit code v lights line v mod MOD
  always_comb begin
    onehot = '0;
    for (int k = 0; k < MOD; k++) begin
      for (int v = 0; v < 4; v++) begin
        if ((v % MOD) == k && slice == 2'(v)) onehot[k] = 1'b1;
      end
    end
    if (!$isunknown(slice)) begin
      // R2
      leaf_onehot_chk: assert ($countones(onehot) == 1)
        else $error("leaf produced %b for slice %0d", onehot, slice);
    end
  end
endmodule

// File: rtl/res_scale.sv
`timescale 1ns/1ps
module res_scale #(
  parameter int MOD    = 5,
  parameter int FACTOR = 1
) (
  input  logic [MOD-1:0] src,
  output logic [MOD-1:0] dst
);
  // multiply a one-hot residue by a constant: pure rewiring
  if (FACTOR == 1) begin : g_pass
    assign dst = src;
  end else begin : g_perm
    for (genvar k = 0; k < MOD; k++) begin : g_line
      assign dst[(k * FACTOR) % MOD] = src[k];
    end
  end
endmodule

// File: rtl/res_add.sv
`timescale 1ns/1ps
module res_add #(
  parameter int MOD = 5
) (
  input  logic [MOD-1:0] a,
  input  logic [MOD-1:0] b,
  output logic [MOD-1:0] sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < MOD; k++) begin
      for (int i = 0; i < MOD; i++) begin
        sum[k] = sum[k] | (a[i] & b[(k - i + MOD) % MOD]);
      end
    end
    if (!$isunknown({a, b}) && $countones(a) == 1 && $countones(b) == 1) begin
      // R1
      merge_onehot_chk: assert ($countones(sum) == 1)
        else $error("merge of %b and %b gave %b", a, b, sum);
    end
  end
endmodule

// File: rtl/res_tree.sv
`timescale 1ns/1ps
module res_tree
  import residue_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int MOD   = 5
) (
  input  logic [WIDTH-1:0] data,
  output logic [MOD-1:0]   onehot
);
  localparam int LEAVES = WIDTH / 2;
  localparam int NODES  = 2 * LEAVES - 1;

  // heap order: node 0 is the root, children of i are 2i+1 (upper) and 2i+2 (lower)
  logic [MOD-1:0] nd [NODES];

  for (genvar i = 0; i < NODES; i++) begin : g_node
    if (i >= LEAVES - 1) begin : g_leaf
      localparam int J = i - (LEAVES - 1);
      res_leaf #(.MOD(MOD)) u_leaf (
        .slice  (data[WIDTH-1-2*J -: 2]),
        .onehot (nd[i])
      );
    end else begin : g_merge
      localparam int DEPTH  = floor_log2(i + 1);
      localparam int HALF   = WIDTH >> (DEPTH + 1);
      localparam int FACTOR = pow2_mod(HALF, MOD);
      logic [MOD-1:0] hi_scaled;
      res_scale #(.MOD(MOD), .FACTOR(FACTOR)) u_scale (
        .src (nd[2*i+1]),
        .dst (hi_scaled)
      );
      res_add #(.MOD(MOD)) u_add (
        .a   (hi_scaled),
        .b   (nd[2*i+2]),
        .sum (nd[i])
      );
    end
  end

  assign onehot = nd[0];
endmodule

// File: rtl/residue_reduce.sv
`timescale 1ns/1ps
module residue_reduce
  import residue_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int MOD     = 7,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [MOD-1:0]   res_onehot
);
  initial begin
    param_width_chk: assert (is_pow2(WIDTH) && WIDTH >= 2 && WIDTH <= 64)
      else $error("WIDTH must be a power of two from 2 to 64");
    param_mod_chk: assert ((MOD % 2) == 1 && MOD >= 3 && MOD <= 15)
      else $error("MOD must be odd, from 3 to 15");
  end

  logic [MOD-1:0] tree_oh;

  res_tree #(.WIDTH(WIDTH), .MOD(MOD)) u_tree (
    .data   (in_data),
    .onehot (tree_oh)
  );

  if (REG_OUT) begin : g_reg
    logic [MOD-1:0] oh_q;
    logic           vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        oh_q  <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) oh_q <= tree_oh;
      end
    end

    assign res_onehot = oh_q;
    assign out_valid  = vld_q;

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(res_onehot)));
    // R1
    onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($countones(res_onehot) == 1));
  end else begin : g_comb
    assign res_onehot = tree_oh;
    assign out_valid  = in_valid;
  end
endmodule

// File: tb/residue_reduce_test.sv
`timescale 1ns/1ps
module residue_reduce_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // registered instance: 32 bits, modulus 7
  logic        r_valid = 1'b0;
  logic [31:0] r_data  = '0;
  logic        r_ov;
  logic [6:0]  r_oh;

  // combinational instances
  logic        c_valid = 1'b0;
  logic [15:0] c_data  = '0;
  logic        c_ov;
  logic [4:0]  c_oh;
  logic        t_valid = 1'b0;
  logic [7:0]  t_data  = '0;
  logic        t_ov;
  logic [2:0]  t_oh;

  residue_reduce #(.WIDTH(32), .MOD(7), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(r_valid), .in_data(r_data),
    .out_valid(r_ov), .res_onehot(r_oh));

  residue_reduce #(.WIDTH(16), .MOD(5), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .in_valid(c_valid), .in_data(c_data),
    .out_valid(c_ov), .res_onehot(c_oh));

  residue_reduce #(.WIDTH(8), .MOD(3), .REG_OUT(1'b0)) uut_m3 (
    .clk(clk), .rst(rst), .in_valid(t_valid), .in_data(t_data),
    .out_valid(t_ov), .res_onehot(t_oh));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard
  int    exp_q[$];
  string tag_q[$];
  logic [6:0] last_oh = '0;

  task automatic send(input logic [31:0] d, input string tag);
    @(negedge clk);
    r_valid = 1'b1;
    r_data  = d;
    exp_q.push_back(int'(d % 32'd7));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      r_valid = 1'b0;
      r_data  = $urandom;   // R6: ignored data
    end
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst) begin
      check("R7 reset clears valid", 16'(r_ov), 16'd0);
      check("R7 reset clears residue", 16'(r_oh), 16'd0);
      last_oh = '0;
    end else if (r_ov) begin
      if (exp_q.size() == 0) begin
        check("R5 valid without pending input", 16'(r_ov), 16'd0);
      end else begin
        int    idx;
        string tg;
        idx = exp_q.pop_front();
        tg  = tag_q.pop_front();
        check(tg, 16'(r_oh), 16'(1) << idx);
      end
      last_oh = r_oh;
    end else begin
      check("R6 idle holds residue", 16'(r_oh), 16'(last_oh));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep of the combinational instances
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      c_data  = 16'(v);
      c_valid = v[0];
      t_data  = 8'(v);
      t_valid = ~v[0];
      #1;
      if (v < 4)
        check("R2 leaf decode mod 5", 16'(c_oh), 16'(1) << (v % 5));
      else
        check("R1 R3 scaled merge mod 5", 16'(c_oh), 16'(1) << (v % 5));
      check("R4 comb valid follows", 16'(c_ov), 16'(v[0]));
      if (v < 256) begin
        if (v < 4)
          check("R2 leaf decode mod 3", 16'(t_oh), 16'(1) << (v % 3));
        else
          check("R1 merge mod 3", 16'(t_oh), 16'(1) << (v % 3));
        check("R4 comb valid follows mod 3", 16'(t_ov), 16'(~v[0] & 1));
      end
    end

    // registered instance
    send(32'h0000_0000, "R8 all zero");
    send(32'hFFFF_FFFF, "R8 all ones");
    idle(3);
    for (int n = 0; n < 10000; n++) begin
      if (($urandom % 8) == 0) idle(1);
      else send($urandom, "R5 R1 random word mod 7");
    end
    idle(3);

    // reset while an input is offered: R7
    @(negedge clk);
    rst = 1'b1;
    r_valid = 1'b1;
    r_data = 32'd5;
    @(negedge clk);
    rst = 1'b0;
    r_valid = 1'b0;
    idle(2);
    send(32'd100, "R5 after reset");
    send(32'd1 << 31, "R3 top bit mod 7");
    idle(3);
    check("R5 all results returned", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule